// File: doc/BRIEF.md
# Inbound Ethernet Frame Classifier

This block sits behind a receive MAC and sorts each incoming Ethernet frame onto one of two outputs. It takes frames as a byte stream with first and last flags. It holds the first 42 bytes while it reads the address and header fields, and then makes a routing decision before any payload moves on. Frames addressed to this node that carry UDP traffic for the programmed port window go out the fast path. The fast path is meant for application radio data, and it carries only the UDP payload. Every other accepted frame goes out the slow path whole, for a processor to handle. Every forwarded frame is prefixed with its two-byte Ethertype.

The node's MAC address, its IPv4 address and the base fast port come in as configuration inputs. The base port marks traffic for the radio transport receiver. The next four ports select application channels 0 to 3, and the fast path carries this channel tag beside the data. The processor returns a one-cycle acknowledge for each slow-path frame it has taken out of its buffer. The block uses these acknowledges to limit the number of slow-path frames that are waiting.

Top module: `pkt_classifier`

## Requirements
- R1: A frame is forwarded only if bytes 0..5 equal `local_mac` or are all ones. Any other frame produces no output on either path.
- R2: Every forwarded frame begins with two tag bytes that hold the Ethertype (frame bytes 12..13), high byte first.
- R3: A frame takes the fast path only when all of these hold: the Ethertype is 0x0800, byte 23 is 17, bytes 30..33 equal `local_ip`, and the port in bytes 36..37 lies in `fast_port` to `fast_port+4`. The fast output is the tag followed by frame bytes 42 onward.
- R4: On the fast path, `fp_vita` is 1 when the port equals `fast_port`. Otherwise `fp_vita` is 0 and `fp_app` equals port − `fast_port` − 1.
- R5: An accepted frame that fails R3, including ARP (0x0806), goes to the slow path as the tag followed by every byte of the frame.
- R6: A frame shorter than 42 bytes is discarded. A fast frame of exactly 42 bytes yields only the two tag bytes, with last set on the second.
- R7: At most `SLOW_SLOTS` slow frames are outstanding at any time. Each `slow_ack` pulse frees one slot. A slow-bound frame that arrives while all slots are taken is dropped. An acknowledge with nothing outstanding has no effect.
- R8: While an output is valid and not ready, its data and flags hold. Input backpressure follows the selected output's ready during payload transfer.
- R9: A frame appears on at most one path. First is set on its first output byte and last on its final byte, and the two paths are never valid together.
- R10: After reset, neither output is valid and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mac | input | 48 | This node's MAC address |
| local_ip | input | 32 | This node's IPv4 address |
| fast_port | input | 16 | Base UDP port of the fast window |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | First byte of a frame |
| in_last | input | 1 | Last byte of a frame |
| in_ready | output | 1 | Input byte accepted |
| fp_valid | output | 1 | Fast path byte valid |
| fp_data | output | 8 | Fast path byte |
| fp_first | output | 1 | Fast path first byte |
| fp_last | output | 1 | Fast path last byte |
| fp_vita | output | 1 | Fast frame is radio-transport traffic |
| fp_app | output | 2 | Fast frame application channel |
| fp_ready | input | 1 | Fast path sink ready |
| sp_valid | output | 1 | Slow path byte valid |
| sp_data | output | 8 | Slow path byte |
| sp_first | output | 1 | Slow path first byte |
| sp_last | output | 1 | Slow path last byte |
| sp_ready | input | 1 | Slow path sink ready |
| slow_ack | input | 1 | One slow frame removed from the processor buffer |

## Verification
The hold checks assume that upstream keeps `in_valid` and the input byte steady until the byte is accepted. This matters because payload bytes pass straight through to the output. The slot check assumes the processor acknowledges only frames it has actually received, never a frame that is still being decided or replayed. The bench changes inputs and readies just after a clock edge and holds each byte until it sees `in_ready`. It issues acknowledges only when the block is idle, and it issues the extra acknowledge at zero only when nothing is in flight.

// File: rtl/pkt_classifier.sv
module pkt_classifier #(
  parameter int SLOW_SLOTS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] local_mac,
  input  logic [31:0] local_ip,
  input  logic [15:0] fast_port,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_first,
  input  logic        in_last,
  output logic        in_ready,
  output logic        fp_valid,
  output logic [7:0]  fp_data,
  output logic        fp_first,
  output logic        fp_last,
  output logic        fp_vita,
  output logic [1:0]  fp_app,
  input  logic        fp_ready,
  output logic        sp_valid,
  output logic [7:0]  sp_data,
  output logic        sp_first,
  output logic        sp_last,
  input  logic        sp_ready,
  input  logic        slow_ack
);
  localparam int HDR_LEN = 42;
  localparam int CW = $clog2(HDR_LEN + 3);
  localparam int SW = $clog2(SLOW_SLOTS + 1);

  typedef enum logic [2:0] {S_HDR, S_DECIDE, S_REPLAY, S_PASS, S_DROP} st_t;
  st_t st;

  logic [7:0]    hdr [HDR_LEN];
  logic [CW-1:0] cnt, ridx, rlen;
  logic          ended, to_fast;
  logic [SW-1:0] slow_used;
  logic          out_valid, out_first, out_last, out_ready;
  logic [7:0]    out_data;

  wire [CW-1:0] widx   = in_first ? '0 : cnt;
  wire [CW-1:0] hidx   = ridx - CW'(2);
  wire [47:0]   dmac   = {hdr[0], hdr[1], hdr[2], hdr[3], hdr[4], hdr[5]};
  wire [15:0]   etype  = {hdr[12], hdr[13]};
  wire [31:0]   dip    = {hdr[30], hdr[31], hdr[32], hdr[33]};
  wire [15:0]   dport  = {hdr[36], hdr[37]};
  wire [15:0]   port_off = dport - fast_port;
  wire          mac_ok = (dmac == local_mac) || (dmac == '1);
  wire          is_fast = (etype == 16'h0800) && (hdr[23] == 8'd17) &&
                          (dip == local_ip) && (port_off <= 16'd4);
  wire          slow_full = (slow_used == SW'(SLOW_SLOTS));
  wire          slow_inc = (st == S_DECIDE) && mac_ok && !is_fast && !slow_full;
  wire          slow_dec = slow_ack && (slow_used != '0);
  wire [7:0]    rbyte  = (ridx == '0) ? etype[15:8] :
                         (ridx == CW'(1)) ? etype[7:0] : hdr[hidx];

  always_comb begin
    out_valid = 1'b0;
    out_data  = rbyte;
    out_first = 1'b0;
    out_last  = 1'b0;
    in_ready  = 1'b0;
    case (st)
      S_HDR:    in_ready = 1'b1;
      S_REPLAY: begin
        out_valid = 1'b1;
        out_first = (ridx == '0);
        out_last  = ended && (ridx == rlen - CW'(1));
      end
      S_PASS: begin
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last;
        in_ready  = out_ready;
      end
      S_DROP:   in_ready = 1'b1;
      default:  ;
    endcase
  end

  assign out_ready = to_fast ? fp_ready : sp_ready;
  assign fp_valid  = out_valid && to_fast;
  assign sp_valid  = out_valid && !to_fast;
  assign fp_data   = out_data;
  assign sp_data   = out_data;
  assign fp_first  = out_first;
  assign sp_first  = out_first;
  assign fp_last   = out_last;
  assign sp_last   = out_last;

  always_ff @(posedge clk)
    if (st == S_HDR && in_valid) hdr[widx] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_HDR;
      cnt       <= '0;
      ridx      <= '0;
      rlen      <= '0;
      ended     <= 1'b0;
      to_fast   <= 1'b0;
      fp_vita   <= 1'b0;
      fp_app    <= '0;
      slow_used <= '0;
    end else begin
      if (slow_inc && !slow_dec) slow_used <= slow_used + SW'(1);
      else if (slow_dec && !slow_inc) slow_used <= slow_used - SW'(1);
      case (st)
        S_HDR: if (in_valid) begin
          if (widx == CW'(HDR_LEN - 1)) begin
            cnt   <= '0;
            ended <= in_last;
            st    <= S_DECIDE;
          end else if (in_last) cnt <= '0;
          else cnt <= widx + CW'(1);
        end
        S_DECIDE: begin
          ridx <= '0;
          if (!mac_ok || (!is_fast && slow_full)) st <= ended ? S_HDR : S_DROP;
          else begin
            to_fast <= is_fast;
            rlen    <= is_fast ? CW'(2) : CW'(HDR_LEN + 2);
            fp_vita <= (port_off == 16'd0);
            fp_app  <= port_off[1:0] - 2'd1;
            st      <= S_REPLAY;
          end
        end
        S_REPLAY: if (out_ready) begin
          if (ridx == rlen - CW'(1)) st <= ended ? S_HDR : S_PASS;
          else ridx <= ridx + CW'(1);
        end
        S_PASS: if (in_valid && out_ready && in_last) st <= S_HDR;
        S_DROP: if (in_valid && in_last) st <= S_HDR;
        default: st <= S_HDR;
      endcase
    end
  end
endmodule

// File: rtl/pkt_classifier_chk.sv
module pkt_classifier_chk #(
  parameter int SLOW_SLOTS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fp_valid,
  input logic       fp_ready,
  input logic [7:0] fp_data,
  input logic       fp_first,
  input logic       fp_last,
  input logic       sp_valid,
  input logic       sp_ready,
  input logic [7:0] sp_data,
  input logic       sp_first,
  input logic       sp_last,
  input logic       slow_ack
);
  int outst;

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= 0;
    else outst <= outst + ((sp_valid && sp_ready && sp_first) ? 1 : 0)
                        - ((slow_ack && outst > 0) ? 1 : 0);
  end

  assert_hold_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fp_valid && !fp_ready |=> fp_valid && $stable(fp_data) && $stable(fp_first) && $stable(fp_last));

  assert_hold_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid && !sp_ready |=> sp_valid && $stable(sp_data) && $stable(sp_first) && $stable(sp_last));

  assert_one_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fp_valid, sp_valid}) <= 1);

  assert_slot_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= SLOW_SLOTS);

  assert_fast_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fp_valid && fp_first |-> fp_data == 8'h08);
endmodule

bind pkt_classifier pkt_classifier_chk #(.SLOW_SLOTS(SLOW_SLOTS)) chk_i (.*);

// File: tb/pkt_classifier_tb_top.sv
module pkt_classifier_tb_top;
  localparam logic [47:0] LMAC  = 48'h02_11_22_33_44_55;
  localparam logic [31:0] LIP   = 32'hC0A8_0A05;
  localparam logic [15:0] FPORT = 16'd1000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, fp_ready = 1, sp_ready = 1, slow_ack = 0;
  logic [7:0] in_data = 0;
  logic in_ready, fp_valid, fp_first, fp_last, fp_vita, sp_valid, sp_first, sp_last;
  logic [1:0] fp_app;
  logic [7:0] fp_data, sp_data;

  int checks = 0, fails = 0;
  logic [7:0] frame[$];
  logic [7:0] fq[$], sq[$];
  logic fqf[$], fql[$], sqf[$], sql[$];
  logic got_vita;
  logic [1:0] got_app;

  always #5 clk = ~clk;

  pkt_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .local_mac(LMAC), .local_ip(LIP), .fast_port(FPORT),
    .in_valid(in_valid), .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_ready(in_ready), .fp_valid(fp_valid), .fp_data(fp_data), .fp_first(fp_first),
    .fp_last(fp_last), .fp_vita(fp_vita), .fp_app(fp_app), .fp_ready(fp_ready),
    .sp_valid(sp_valid), .sp_data(sp_data), .sp_first(sp_first), .sp_last(sp_last),
    .sp_ready(sp_ready), .slow_ack(slow_ack));

  always @(negedge clk) if (rst_n) begin
    if (fp_valid && fp_ready) begin
      fq.push_back(fp_data); fqf.push_back(fp_first); fql.push_back(fp_last);
      if (fp_first) begin got_vita = fp_vita; got_app = fp_app; end
    end
    if (sp_valid && sp_ready) begin
      sq.push_back(sp_data); sqf.push_back(sp_first); sql.push_back(sp_last);
    end
  end

  task automatic check(input string req, input string what, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_q(input string req, input string nm, input logic [7:0] exp[$],
                         input logic [7:0] got[$], input logic gf[$], input logic gl[$]);
    logic ok = (got.size() == exp.size());
    int nf = 0, nl = 0, bad = -1;
    for (int i = 0; i < got.size() && ok; i++) begin
      if (got[i] != exp[i]) begin ok = 0; bad = i; end
      nf += int'(gf[i]); nl += int'(gl[i]);
    end
    if (ok && got.size() > 0) ok = gf[0] && gl[got.size()-1] && nf == 1 && nl == 1;
    if (bad >= 0)
      check(req, $sformatf("%s byte %0d", nm, bad), 0, got[bad], exp[bad]);
    else
      check(req, $sformatf("%s length/flags", nm), ok, got.size(), exp.size());
  endtask

  task automatic build(input logic [47:0] mac, input logic [15:0] et, input logic [7:0] pr,
                       input logic [31:0] ip, input logic [15:0] port, input int plen);
    frame.delete();
    for (int i = 0; i < 42 + plen; i++) frame.push_back(8'(i * 3 + 1));
    for (int k = 0; k < 6; k++) frame[k] = mac[47 - 8*k -: 8];
    frame[12] = et[15:8]; frame[13] = et[7:0]; frame[23] = pr;
    for (int k = 0; k < 4; k++) frame[30 + k] = ip[31 - 8*k -: 8];
    frame[36] = port[15:8]; frame[37] = port[7:0];
  endtask

  task automatic push(input logic [7:0] b, input logic f, input logic l);
    logic acc;
    in_valid = 1; in_data = b; in_first = f; in_last = l;
    forever begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
  endtask

  task automatic send;
    fq.delete(); fqf.delete(); fql.delete(); sq.delete(); sqf.delete(); sql.delete();
    @(posedge clk); #1;
    for (int i = 0; i < frame.size(); i++) push(frame[i], i == 0, i == frame.size() - 1);
    in_valid = 0; in_first = 0; in_last = 0;
    repeat (80) @(posedge clk);
  endtask

  task automatic ack;
    @(posedge clk); #1 slow_ack = 1;
    @(posedge clk); #1 slow_ack = 0;
  endtask

  function automatic void fast_exp(output logic [7:0] e[$]);
    e = {8'h08, 8'h00};
    for (int i = 42; i < frame.size(); i++) e.push_back(frame[i]);
  endfunction

  function automatic void slow_exp(output logic [7:0] e[$]);
    e = {frame[12], frame[13]};
    for (int i = 0; i < frame.size(); i++) e.push_back(frame[i]);
  endfunction

  task automatic t_fast_vita;
    logic [7:0] e[$], none[$];
    build(LMAC, 16'h0800, 8'd17, LIP, FPORT, 6); send;
    fast_exp(e);
    check_q("R3", "fast vita", e, fq, fqf, fql);
    check_q("R9", "slow idle", none, sq, sqf, sql);
    check("R4", "vita flag", got_vita == 1, got_vita, 1);
  endtask

  task automatic t_fast_app;
    logic [7:0] e[$];
    build(48'hFFFF_FFFF_FFFF, 16'h0800, 8'd17, LIP, FPORT + 16'd3, 9); send;
    fast_exp(e);
    check_q("R1", "broadcast fast", e, fq, fqf, fql);
    check("R4", "app channel", got_vita == 0 && got_app == 2, int'(got_app), 2);
  endtask

  task automatic t_slow(input string req, input string nm, input logic [15:0] et,
                        input logic [7:0] pr, input logic [31:0] ip, input logic [15:0] port);
    logic [7:0] e[$], none[$];
    build(LMAC, et, pr, ip, port, 5); send;
    slow_exp(e);
    check_q(req, nm, e, sq, sqf, sql);
    check_q("R9", {nm, " fast idle"}, none, fq, fqf, fql);
    ack;
  endtask

  task automatic t_wrong_mac;
    logic [7:0] none[$];
    build(48'h02_11_22_33_44_56, 16'h0800, 8'd17, LIP, FPORT, 4); send;
    check_q("R1", "foreign mac fast", none, fq, fqf, fql);
    check_q("R1", "foreign mac slow", none, sq, sqf, sql);
  endtask

  task automatic t_short;
    logic [7:0] none[$], e[$];
    build(LMAC, 16'h0806, 8'd0, LIP, FPORT, 0);
    while (frame.size() > 30) void'(frame.pop_back());
    send;
    check_q("R6", "short frame", none, sq, sqf, sql);
    build(LMAC, 16'h0800, 8'd17, LIP, FPORT + 16'd1, 0); send;
    e = {8'h08, 8'h00};
    check_q("R6", "42-byte fast", e, fq, fqf, fql);
    check("R4", "app 0", got_app == 0 && got_vita == 0, int'(got_app), 0);
  endtask

  task automatic t_slots;
    int n;
    for (int i = 0; i < 6; i++) ack;
    n = 0;
    for (int i = 0; i < 3; i++) begin
      build(LMAC, 16'h0806, 8'd0, 32'h0, 16'h0, 2); send;
      n += (sq.size() > 0) ? 1 : 0;
    end
    check("R7", "frames delivered with two slots", n == 2, n, 2);
    ack;
    build(LMAC, 16'h0806, 8'd0, 32'h0, 16'h0, 2); send;
    check("R7", "delivery after ack", sq.size() > 0, sq.size(), 46);
    ack; ack; ack;
    n = 0;
    for (int i = 0; i < 3; i++) begin
      build(LMAC, 16'h0806, 8'd0, 32'h0, 16'h0, 2); send;
      n += (sq.size() > 0) ? 1 : 0;
    end
    check("R7", "ack at zero ignored", n == 2, n, 2);
    ack; ack;
  endtask

  task automatic t_backpressure;
    logic [7:0] e[$];
    build(LMAC, 16'h0800, 8'd17, LIP, FPORT + 16'd4, 20);
    fork
      send;
      repeat (150) begin @(posedge clk); #1 fp_ready = ~fp_ready; end
    join
    fp_ready = 1;
    repeat (80) @(posedge clk);
    fast_exp(e);
    check_q("R8", "fast under backpressure", e, fq, fqf, fql);
    check("R4", "app 3", got_app == 3, int'(got_app), 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "fp_valid in reset", fp_valid == 0, fp_valid, 0);
    check("R10", "sp_valid in reset", sp_valid == 0, sp_valid, 0);
    check("R10", "in_ready in reset", in_ready == 1, in_ready, 1);
    rst_n = 1;
    t_fast_vita;
    t_fast_app;
    t_slow("R5", "foreign ip", 16'h0800, 8'd17, LIP + 32'd1, FPORT);
    t_slow("R5", "arp", 16'h0806, 8'd0, LIP, FPORT);
    t_slow("R3", "tcp proto", 16'h0800, 8'd6, LIP, FPORT);
    t_slow("R3", "port beyond window", 16'h0800, 8'd17, LIP, FPORT + 16'd5);
    t_slow("R2", "odd ethertype tag", 16'h86DD, 8'd17, LIP, FPORT);
    t_wrong_mac;
    t_short;
    t_slots;
    t_backpressure;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule